// File: doc/BRIEF.md
# Signed Carry-Save Array Multiplier

This block multiplies two signed operands of `N` bits each and returns their product in `2N` bits. It is purely combinational. There is no clock, no register and no handshake. The product follows the operands within the same evaluation, so a surrounding pipeline can place it between two register stages of its own choosing.

The datapath is a square, regular carry-save array. Each cell combines a one-bit partial-product gate with an adder, and no carry ripples inside a row. Partial-product bits that pair one operand's sign bit with a magnitude bit of the other operand are produced inverted, through a NAND. The single fixed constant `2^N + 2^(2N-1)` is loaded into the carry vector that enters the first row. This removes the offset that the inversions introduce, so the array needs no sign extension and no recoding.

A full-width ripple carry adder merges the saved sum and carry vectors into the final product. Anything that would fall above bit `2N-1` is dropped. The operand width is a parameter, with a default of 3.

Top module: `smul_array`

## Requirements
- R1: For every pair of operands, `prod` equals the two's-complement product of `op_a` and `op_b`, written as a `2N`-bit two's-complement value.
- R2: A partial-product bit that pairs a sign bit (bit `N-1`) with a non-sign bit is inverted. At the ports this shows as the most negative operand `-2^(N-1)` times a positive `b` giving `-2^(N-1)*b`, in both operand orders.
- R3: The partial-product bit that pairs the two sign bits is a plain AND. The most negative value squared gives `+2^(2N-2)`, which is `010000` for `N=3`.
- R4: The injected correction `2^N + 2^(2N-1)` cancels exactly. When either operand is zero, `prod` is all zeros.
- R5: Carries beyond bit `2N-1` are discarded. `(-1)*(-1)` gives `1`, and `(-1)*(-2^(N-1))` gives `+2^(N-1)`.
- R6: For `N=3`, `op_a=011` (3) times `op_b=111` (-1) gives `prod=111101` (-3).
- R7: Swapping the operands never changes `prod`.
- R8: When both operands are non-zero, bit `2N-1` of `prod` equals the XOR of the two operand sign bits.
- R9: `prod` follows a change of the operands without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First signed operand (two's complement) |
| op_b | input | N | Second signed operand (two's complement) |
| prod | output | 2N | Signed product (two's complement) |

## Verification
Assertions embedded in the RTL run on every evaluation. They check three things against the port values: the product against a behavioural signed multiply, the all-zero result for a zero operand, and the sign rule. Each adder cell also checks its own arithmetic weight, and the final adder is checked against a plain addition. Operand-swap invariance and the specific bit patterns for the most negative operand and for the worked case 3 times -1 are shown only by the bench. The bench sweeps every operand pair at widths 3 and 4 and compares results across separate evaluations.

// File: rtl/smul_pkg.sv
package smul_pkg;

    // Sum and carry leaving one adder cell of the array.
    typedef struct packed {
        logic c;
        logic s;
    } csa_pair_t;

    // Fixed offset that cancels the ones added by inverting the
    // sign-by-magnitude partial products: 2^n + 2^(2n-1).
    function automatic longint unsigned corr_const(input int n);
        longint unsigned v;
        v = (longint'(1) << n) | (longint'(1) << (2 * n - 1));
        return v;
    endfunction

    // A partial-product bit a[k]&b[j] is inverted when exactly one of
    // its two indices is the sign position.
    function automatic bit pp_inv(input int k, input int j, input int n);
        return (k == n - 1) != (j == n - 1);
    endfunction

endpackage

// File: rtl/smul_mcell.sv
// Array cell: one partial-product gate feeding a full adder.
module smul_mcell #(
    parameter bit INV = 1'b0
) (
    input  logic                a_bit,
    input  logic                b_bit,
    input  logic                s_in,
    input  logic                c_in,
    output smul_pkg::csa_pair_t out
);
    logic pp;

    generate
        if (INV) begin : g_nand
            assign pp = ~(a_bit & b_bit);
        end else begin : g_and
            assign pp = a_bit & b_bit;
        end
    endgenerate

    assign out.s = s_in ^ c_in ^ pp;
    assign out.c = (s_in & c_in) | (s_in & pp) | (c_in & pp);

    always_comb begin
        if (!$isunknown({s_in, c_in, a_bit, b_bit})) begin
            AST_CELL_WEIGHT: assert ({out.c, out.s} == 2'(s_in) + 2'(c_in) + 2'(INV ^ (a_bit & b_bit)))
                else $error("cell weight mismatch"); // R2
        end
    end
endmodule

// File: rtl/smul_half.sv
// Array position with no partial product: a half adder on sum and carry.
module smul_half (
    input  logic                s_in,
    input  logic                c_in,
    output smul_pkg::csa_pair_t out
);
    assign out.s = s_in ^ c_in;
    assign out.c = s_in & c_in;

    always_comb begin
        if (!$isunknown({s_in, c_in})) begin
            AST_HALF_WEIGHT: assert ({out.c, out.s} == 2'(s_in) + 2'(c_in))
                else $error("half cell weight mismatch"); // R1
        end
    end
endmodule

// File: rtl/smul_cpa.sv
// Final row: ripple carry adder merging saved sum and carry vectors.
module smul_cpa #(
    parameter int W = 6
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);
    logic [W:0] chain;

    assign chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]     = x[i] ^ y[i] ^ chain[i];
            assign chain[i+1] = (x[i] & y[i]) | (x[i] & chain[i]) | (y[i] & chain[i]);
        end
    endgenerate

    always_comb begin
        if (!$isunknown({x, y})) begin
            AST_RIPPLE_EXACT: assert ({chain[W], sum} == (W+1)'(x) + (W+1)'(y))
                else $error("ripple adder mismatch"); // R5
        end
    end
endmodule

// File: rtl/smul_array.sv
module smul_array #(
    parameter int N = 3
) (
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] prod
);
    import smul_pkg::*;

    localparam int          W    = 2 * N;
    localparam logic [W-1:0] CORR = W'(corr_const(N));

    // s_vec[j]/c_vec[j] are the saved vectors entering row j.
    logic [W-1:0] s_vec [0:N];
    logic [W-1:0] c_vec [0:N];

    assign s_vec[0] = '0;
    assign c_vec[0] = CORR;   // correction rides in on the first carry vector

    generate
        for (genvar j = 0; j < N; j++) begin : g_row
            logic [W-1:0] rs;
            logic [W-1:0] cy;

            assign cy[0] = 1'b0;

            for (genvar i = 0; i < W; i++) begin : g_col
                if (i == W - 1) begin : g_top
                    // Topmost column: carry out would leave the product.
                    assign rs[i] = s_vec[j][i] ^ c_vec[j][i];
                end else if (i >= j && i <= j + N - 1) begin : g_pp
                    csa_pair_t pr;
                    smul_mcell #(.INV(pp_inv(i - j, j, N))) u_cell (
                        .a_bit (op_a[i-j]),
                        .b_bit (op_b[j]),
                        .s_in  (s_vec[j][i]),
                        .c_in  (c_vec[j][i]),
                        .out   (pr)
                    );
                    assign rs[i]   = pr.s;
                    assign cy[i+1] = pr.c;
                end else begin : g_pass
                    csa_pair_t pr;
                    smul_half u_half (
                        .s_in (s_vec[j][i]),
                        .c_in (c_vec[j][i]),
                        .out  (pr)
                    );
                    assign rs[i]   = pr.s;
                    assign cy[i+1] = pr.c;
                end
            end

            assign s_vec[j+1] = rs;
            assign c_vec[j+1] = cy;
        end
    endgenerate

    smul_cpa #(.W(W)) u_cpa (
        .x   (s_vec[N]),
        .y   (c_vec[N]),
        .sum (prod)
    );

    always_comb begin
        logic signed [W-1:0] ext_a;
        logic signed [W-1:0] ext_b;
        logic signed [W-1:0] ref_p;
        ext_a = W'($signed(op_a));
        ext_b = W'($signed(op_b));
        ref_p = ext_a * ext_b;
        if (!$isunknown({op_a, op_b})) begin
            AST_SIGNED_PRODUCT: assert (prod == ref_p)
                else $error("product mismatch"); // R1
            AST_ZERO_OPERAND: assert (!(op_a == '0 || op_b == '0) || prod == '0)
                else $error("zero operand gave non-zero product"); // R4
            AST_SIGN_XOR: assert (op_a == '0 || op_b == '0 || prod[W-1] == (op_a[N-1] ^ op_b[N-1]))
                else $error("product sign wrong"); // R8
        end
    end
endmodule

// File: tb/smul_array_tb.sv
module smul_array_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [2:0] a3 = '0, b3 = '0;
    logic [5:0] p3;
    logic [3:0] a4 = '0, b4 = '0;
    logic [7:0] p4;

    smul_array #(.N(3)) u_dut  (.op_a(a3), .op_b(b3), .prod(p3));
    smul_array #(.N(4)) u_dut4 (.op_a(a4), .op_b(b4), .prod(p4));

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [5:0] tab3 [64];
    logic [7:0] tab4 [256];

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sx(input int v, input int n);
        return (v >= (1 << (n - 1))) ? v - (1 << n) : v;
    endfunction

    function automatic int expv(input int a, input int b, input int n);
        return (sx(a, n) * sx(b, n)) & ((1 << (2 * n)) - 1);
    endfunction

    // Drive operands, wait away from any edge, read the product (R9: no clock used).
    task automatic apply(input int n, input int a, input int b, output int p);
        if (n == 3) begin a3 = 3'(a); b3 = 3'(b); end
        else        begin a4 = 4'(a); b4 = 4'(b); end
        #(CLK_PERIOD);
        p = (n == 3) ? int'(p3) : int'(p4);
    endtask

    initial begin
        int p;
        #(CLK_PERIOD/2);
        // R9: quiescent all-zero operands give zero at both widths
        check("R9 idle n3", p3, 0);
        check("R9 idle n4", p4, 0);

        for (int n = 3; n <= 4; n++) begin
            int lim;
            lim = 1 << n;
            for (int a = 0; a < lim; a++) begin
                for (int b = 0; b < lim; b++) begin
                    apply(n, a, b, p);
                    check("R1 sweep", p, expv(a, b, n));
                    if (n == 3) tab3[a*8+b] = 6'(p); else tab4[a*16+b] = 8'(p);
                    if (a != 0 && b != 0)
                        check("R8 sign", (p >> (2*n-1)) & 1, int'(sx(a, n) < 0) ^ int'(sx(b, n) < 0));
                end
            end
            // R7: operand swap
            for (int a = 0; a < lim; a++)
                for (int b = a + 1; b < lim; b++)
                    if (n == 3) check("R7 swap", tab3[a*8+b], tab3[b*8+a]);
                    else        check("R7 swap", tab4[a*16+b], tab4[b*16+a]);

            begin
                int mn, m1, mask;
                mn   = 1 << (n - 1);       // bit pattern of -2^(n-1)
                m1   = lim - 1;            // bit pattern of -1
                mask = (1 << (2 * n)) - 1;
                for (int b = 1; b < mn; b++) begin
                    apply(n, mn, b, p);
                    check("R2 min*pos", p, (-(mn) * b) & mask);
                    apply(n, b, mn, p);
                    check("R2 pos*min", p, (-(mn) * b) & mask);
                end
                apply(n, mn, mn, p);
                check("R3 min*min", p, 1 << (2 * n - 2));
                for (int b = 0; b < lim; b++) begin
                    apply(n, 0, b, p);
                    check("R4 zero a", p, 0);
                    apply(n, b, 0, p);
                    check("R4 zero b", p, 0);
                end
                apply(n, m1, m1, p);
                check("R5 -1*-1", p, 1);
                apply(n, m1, mn, p);
                check("R5 -1*min", p, mn);
            end
        end

        apply(3, 3, 7, p);
        check("R6 3*-1", p, 6'b111101);
        apply(3, 7, 3, p);
        check("R6 -1*3", p, 6'b111101);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule